// File: doc/BRIEF.md
# Key-Gated GPIO Pin Lock Unit

This block guards the per-pin configuration registers of a GPIO controller that groups its pins into 32-pin banks. Each bank has one lock word. A set bit in that word write-protects the configuration register of the matching pin, and a clear bit lets software change it. All pins start protected when reset is released.

A lock word cannot be changed by a single store. Software first writes a fixed key value to a key register. Its very next bus write must then target a lock word, and that word is loaded. Any other next write spends the key, and so does a lock write made without a key. Lock words can be read back at any time.

A small array of per-pin configuration registers sits behind the lock, so the protection can be observed. A write to a protected pin is dropped and raises a sticky violation flag, which software can read and clear. A registered vector shows, for each pin, whether its configuration register may be written at present.

Top module: `gpio_lock_guard`

## Requirements
- R1: After reset every lock bit reads 1, `cfg_allow` is all zeros and the violation flag (offset 0x524, bit 0) reads 0.
- R2: Writing 0x00A5A501 to the key register at 0x520, with the next bus write going to 0x500 + 4*b, loads bank b's lock word with the written data. Bit i of word b governs pin 32*b + i, and 1 means locked.
- R3: A lock-word write is ignored when the previous bus write was not a correct key write. This covers no key at all, a wrong key value, and a second lock write after one key, since a key serves only one lock write.
- R4: Idle cycles and reads between the key write and the lock-word write do not cancel the key.
- R5: A write to the configuration register at 0x100 + 4*p of an unlocked pin p is stored and reads back unchanged.
- R6: A write to the configuration register of a locked pin leaves the stored value unchanged and sets the violation flag, which stays set.
- R7: A write to 0x524 with data bit 0 = 1 clears the violation flag.
- R8: Reads return data in the cycle after the read request. Lock words read correctly without a key. A read in the same cycle as a write to the same register returns the value from before the write.
- R9: Reads of unmapped offsets return 0. A write to an unmapped offset cancels a pending key.
- R10: `cfg_allow[p]` is the inverse of pin p's lock bit. It changes in the cycle after the lock-word write that alters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| cfg_allow | output | NUM_BANKS*32 | Per-pin flag: configuration write allowed |

## Verification
The write port and the read port are independent, so a register can be read in the same cycle it is changed. Two cases matter. A lock word can be read while a key-backed write replaces it. The violation flag can be read while a write to a locked pin sets it. The bench drives both ports in one cycle for each case. It expects the value from before the write on `rd_data`, and it expects the new value from a read in the following cycle. It also checks that `cfg_allow` changes exactly one cycle after the lock write and not earlier.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

  localparam int unsigned BUS_AW = 12;
  localparam int unsigned BUS_DW = 32;

  localparam int unsigned CTRL_BASE = 32'h100;
  localparam int unsigned LOCK_BASE = 32'h500;
  localparam int unsigned KEY_OFS   = 32'h520;
  localparam int unsigned ERR_OFS   = 32'h524;

  localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h00A5A501;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_CTRL,
    RGN_LOCK,
    RGN_KEY,
    RGN_ERR
  } rgn_e;

  function automatic rgn_e classify(input logic [BUS_AW-1:0] a,
                                    input int unsigned npins,
                                    input int unsigned nbanks);
    int unsigned v;
    v = 32'(a);
    if (a[1:0] != 2'b00)                                    return RGN_NONE;
    if (v == KEY_OFS)                                       return RGN_KEY;
    if (v == ERR_OFS)                                       return RGN_ERR;
    if (v >= LOCK_BASE && v < LOCK_BASE + 4 * nbanks)       return RGN_LOCK;
    if (v >= CTRL_BASE && v < CTRL_BASE + 4 * npins)        return RGN_CTRL;
    return RGN_NONE;
  endfunction

endpackage

// File: rtl/gpio_lock_keygate.sv
module gpio_lock_keygate
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned BANK_IW   = 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  rgn_e                               wr_rgn,
  input  logic [BANK_IW-1:0]                 wr_bank,
  input  logic [BUS_DW-1:0]                  wr_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]   lock_q
);

  logic key_pend_q;
  logic lock_wr;

  assign lock_wr = wr_en && (wr_rgn == RGN_LOCK) && key_pend_q;

  // Every bus write re-decides the key; only a correct key write arms it.
  always_ff @(posedge clk) begin
    if (rst) begin
      key_pend_q <= 1'b0;
    end else if (wr_en) begin
      key_pend_q <= (wr_rgn == RGN_KEY) && (wr_data == UNLOCK_KEY);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q[b] <= '1;
      end else if (lock_wr && (32'(wr_bank) == b)) begin
        lock_q[b] <= wr_data[BANK_W-1:0];
      end
    end
  end

  AST_LOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    !$stable(lock_q) |-> $past(key_pend_q)); // R3

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_rgn == RGN_LOCK && key_pend_q) |=> !key_pend_q); // R3

  AST_RESET_LOCKED: assert property (@(posedge clk)
    $fell(rst) |-> (&lock_q)); // R1

endmodule

// File: rtl/gpio_lock_ctrlmem.sv
module gpio_lock_ctrlmem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, read-before-write, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/gpio_lock_guard.sv
module gpio_lock_guard
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [11:0]                   wr_addr,
  input  logic [31:0]                   wr_data,
  input  logic                          rd_en,
  input  logic [11:0]                   rd_addr,
  output logic [31:0]                   rd_data,
  output logic [NUM_BANKS*BANK_W-1:0]   cfg_allow
);

  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W;
  localparam int unsigned BIT_W    = $clog2(BANK_W);
  localparam int unsigned BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned PIN_W    = BANK_IW + BIT_W;

  rgn_e wr_rgn, rd_rgn, rd_sel_q;
  logic [BUS_AW-1:0] wr_coff, wr_loff, rd_coff, rd_loff;
  logic [PIN_W-1:0]   wr_pin, rd_pin;
  logic [BANK_IW-1:0] wr_bank, rd_bank;
  logic [NUM_BANKS-1:0][BANK_W-1:0] lock_q;
  logic pin_locked, ctrl_wr, mem_we, err_q;
  logic [31:0] mem_q, side_q;

  // Address decode on both ports.
  assign wr_rgn  = classify(wr_addr, NUM_PINS, NUM_BANKS);
  assign rd_rgn  = classify(rd_addr, NUM_PINS, NUM_BANKS);
  assign wr_coff = wr_addr - BUS_AW'(CTRL_BASE);
  assign wr_loff = wr_addr - BUS_AW'(LOCK_BASE);
  assign rd_coff = rd_addr - BUS_AW'(CTRL_BASE);
  assign rd_loff = rd_addr - BUS_AW'(LOCK_BASE);
  assign wr_pin  = wr_coff[PIN_W+1:2];
  assign rd_pin  = rd_coff[PIN_W+1:2];
  assign wr_bank = wr_loff[BANK_IW+1:2];
  assign rd_bank = rd_loff[BANK_IW+1:2];

  gpio_lock_keygate #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .BANK_IW   (BANK_IW)
  ) keygate_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_rgn  (wr_rgn),
    .wr_bank (wr_bank),
    .wr_data (wr_data),
    .lock_q  (lock_q)
  );

  assign cfg_allow = ~lock_q;

  // Write path: the lock bit of the addressed pin gates the RAM write.
  assign pin_locked = lock_q[wr_pin[PIN_W-1:BIT_W]][wr_pin[BIT_W-1:0]];
  assign ctrl_wr    = wr_en && (wr_rgn == RGN_CTRL);
  assign mem_we     = ctrl_wr && !pin_locked;

  gpio_lock_ctrlmem #(
    .DEPTH (NUM_PINS),
    .DW    (BUS_DW),
    .AW    (PIN_W)
  ) ctrlmem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_pin),
    .wdata (wr_data),
    .re    (rd_en && (rd_rgn == RGN_CTRL)),
    .raddr (rd_pin),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (ctrl_wr && pin_locked) begin
      err_q <= 1'b1;
    end else if (wr_en && (wr_rgn == RGN_ERR) && wr_data[0]) begin
      err_q <= 1'b0;
    end
  end

  AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_rgn == RGN_CTRL && !cfg_allow[wr_pin]) |=> err_q); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_en && wr_rgn == RGN_ERR && wr_data[0])) |=> err_q); // R7

  // Read path: register everything that is not the RAM, then one final mux.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q <= RGN_NONE;
      side_q   <= '0;
    end else if (rd_en) begin
      rd_sel_q <= rd_rgn;
      unique case (rd_rgn)
        RGN_LOCK: side_q <= 32'(lock_q[rd_bank]);
        RGN_ERR:  side_q <= {31'b0, err_q};
        default:  side_q <= '0;
      endcase
    end
  end

  assign rd_data = (rd_sel_q == RGN_CTRL) ? mem_q : side_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_rgn == RGN_NONE) |=> (rd_data == 32'h0)); // R9

endmodule

// File: tb/gpio_lock_guard_tb_top.sv
module gpio_lock_guard_tb_top;

  localparam int unsigned NB = 2;
  localparam int unsigned NP = NB * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] cfg_allow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_lock_guard #(.NUM_BANKS(NB), .BANK_W(32)) dut_i (
    .clk (clk), .rst (rst),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
    .cfg_allow (cfg_allow)
  );

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h500, 32'hFFFFFFFF, 4'd8},  // R8 readable without key
    '{1'b0, 12'h500, 32'h00000000, 4'd3},  // lock write, no key
    '{1'b1, 12'h500, 32'hFFFFFFFF, 4'd3},  // R3 ignored
    '{1'b0, 12'h520, 32'h00A5A501, 4'd2},
    '{1'b0, 12'h500, 32'hFFFFFFF0, 4'd2},
    '{1'b1, 12'h500, 32'hFFFFFFF0, 4'd2},  // R2 loaded
    '{1'b0, 12'h104, 32'h12345678, 4'd5},
    '{1'b1, 12'h104, 32'h12345678, 4'd5},  // R5 stored
    '{1'b0, 12'h140, 32'hDEADBEEF, 4'd6},  // pin 16 locked
    '{1'b1, 12'h524, 32'h00000001, 4'd6},  // R6 flag set
    '{1'b0, 12'h524, 32'h00000001, 4'd7},
    '{1'b1, 12'h524, 32'h00000000, 4'd7},  // R7 cleared
    '{1'b0, 12'h520, 32'h00A5A501, 4'd4},
    '{1'b1, 12'h504, 32'hFFFFFFFF, 4'd4},  // R4 read between
    '{1'b0, 12'h504, 32'h7FFFFFFF, 4'd4},
    '{1'b1, 12'h504, 32'h7FFFFFFF, 4'd4},  // R4 key survived read
    '{1'b0, 12'h504, 32'h00000000, 4'd3},
    '{1'b1, 12'h504, 32'h7FFFFFFF, 4'd3},  // R3 one-shot
    '{1'b0, 12'h520, 32'h00A5A501, 4'd9},
    '{1'b0, 12'h600, 32'h00000000, 4'd9},  // unmapped write
    '{1'b0, 12'h500, 32'h00000000, 4'd9},
    '{1'b1, 12'h500, 32'hFFFFFFF0, 4'd9},  // R9 key cancelled
    '{1'b1, 12'h600, 32'h00000000, 4'd9},  // R9 unmapped read
    '{1'b0, 12'h520, 32'h12345678, 4'd3},  // wrong key
    '{1'b0, 12'h500, 32'h00000000, 4'd3},
    '{1'b1, 12'h500, 32'hFFFFFFF0, 4'd3},  // R3 wrong key
    '{1'b0, 12'h1FC, 32'hCAFE0001, 4'd5},  // pin 63, bank 1
    '{1'b1, 12'h1FC, 32'hCAFE0001, 4'd5},  // R5 bank mapping
    '{1'b0, 12'h520, 32'h00A5A501, 4'd6},
    '{1'b0, 12'h500, 32'hFFFFFFFF, 4'd6},  // relock bank 0
    '{1'b0, 12'h104, 32'h00000BAD, 4'd6},
    '{1'b1, 12'h104, 32'h12345678, 4'd6},  // R6 dropped
    '{1'b1, 12'h524, 32'h00000001, 4'd6},  // R6 flag
    '{1'b1, 12'h1FC, 32'hCAFE0001, 4'd5}   // R5 unaffected
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, return at the next falling edge.
  task automatic cyc(input logic we, input logic [11:0] wa, input logic [31:0] wd,
                     input logic re, input logic [11:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 12'h0);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b0, 12'h0, 32'h0, 1'b1, a);
    check({32'h0, rd_data}, {32'h0, exp}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(cfg_allow, 64'h0, "R1 cfg_allow after reset");
    rd_chk(12'h524, 32'h0, "R1 flag after reset");
    rd_chk(12'h504, 32'hFFFFFFFF, "R1 bank1 locked");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        cyc(1'b0, 12'h0, 32'h0, 1'b1, VECS[i].addr);
        checks++;
        if (rd_data !== VECS[i].data) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %h expected %h",
                   VECS[i].req, i, rd_data, VECS[i].data);
        end
      end else begin
        wr(VECS[i].addr, VECS[i].data);
      end
    end

    // R10: cfg_allow mirrors the locks, changes one cycle after the write
    check(cfg_allow, 64'h8000_0000_0000_0000, "R10 allow after table");
    wr(12'h520, 32'h00A5A501);
    check(cfg_allow, 64'h8000_0000_0000_0000, "R10 key alone no change");
    wr(12'h500, 32'hFFFFFFFE);
    check(cfg_allow, 64'h8000_0000_0000_0001, "R10 allow after lock write");

    // R8: read and write of the same lock word in one cycle
    wr(12'h520, 32'h00A5A501);
    cyc(1'b1, 12'h500, 32'hFFFFFFFF, 1'b1, 12'h500);
    check({32'h0, rd_data}, {32'h0, 32'hFFFFFFFE}, "R8 same-cycle old value");
    rd_chk(12'h500, 32'hFFFFFFFF, "R8 new value next read");

    // R6/R7: flag read in the same cycle as a violating write
    wr(12'h524, 32'h1);
    cyc(1'b1, 12'h114, 32'h55, 1'b1, 12'h524);
    check({32'h0, rd_data}, 64'h0, "R6 same-cycle flag old");
    rd_chk(12'h524, 32'h1, "R6 flag set after");
    wr(12'h524, 32'h0);
    rd_chk(12'h524, 32'h1, "R7 write of 0 keeps flag");

    // R1: reset again restores locks
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_allow, 64'h0, "R1 cfg_allow after second reset");
    rd_chk(12'h504, 32'hFFFFFFFF, "R1 lock after second reset");
    rd_chk(12'h524, 32'h0, "R1 flag after second reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule